// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory from a set of digital supply-level flags. External comparators report three conditions: the supply is within its operating tolerance, the supply sits above the battery switchover level, and the supply has once risen above the level that releases the shipping seal. Every flag is resynchronised to the block clock and must hold a new value for a set number of cycles before the sequencer acts on it. A five-state machine then drives the interface lockout, the output-tristate force and the supply-source select, and it also reports its own state.

The host side is a plain strobe interface: chip select, write enable and output enable. It carries no stream of data items, so it has no valid/ready handshake and no back-pressure. While the sequencer is in its normal state, the host strobes pass straight through to the array. In every other state the strobes are blocked and the data pins are forced to high impedance. When protection cuts off an access that has already started, the access stays blocked until the host drops chip select, even if the supply recovers first.

The two threshold variants, 4.75 V / 4.5 V and 4.5 V / 4.25 V, only change where the external comparators trip. The digital sequencing is the same for both.

Top module: `pfws_top`

## Requirements
- R1: Each supply flag passes through SYNC_STAGES flops and then a filter that adopts a new value only after it has been stable for DEB_CYCLES consecutive cycles. A pulse shorter than DEB_CYCLES cycles has no effect.
- R2: After reset the state code `pf_state` is 0 (sealed), `seal_intact` is 1, `dq_force_hiz` is 1, `pwr_sel_batt` is 0, `batt_used_sticky` is 0, and `arr_cs`, `arr_we` and `dq_drive_en` are all 0.
- R3: The first time the filtered seal-release flag is high, the seal is released for good and the state moves to recovering, code 4. After that, `seal_intact` stays 0 until the next reset, whatever the flag does.
- R4: While sealed, `pwr_sel_batt` stays 0 for every combination of flags.
- R5: The state is normal, code 1, only while the filtered in-tolerance flag is high. When that flag goes low in normal, the state moves to protected, code 2. `dq_force_hiz` goes to 1 and `arr_cs`, `arr_we` and `dq_drive_en` go to 0.
- R6: When the filtered switchover flag goes low in protected or recovering, the state moves to backup, code 3, and `pwr_sel_batt` goes to 1. `pwr_sel_batt` is 1 only in backup.
- R7: When the switchover flag goes high in backup, the state moves to recovering. The main supply is selected again and the interface stays locked. The state reaches normal only when the in-tolerance flag is high; this applies from protected as well as from recovering.
- R8: In normal, `arr_cs` equals `host_cs`, `arr_we` equals `host_cs & host_we`, and `dq_drive_en` equals `host_cs & host_oe & ~host_we`.
- R9: If `host_cs` is high when the lock asserts, the array strobes are cut in that same cycle. They stay 0, even back in normal, until `host_cs` has been seen low.
- R10: `batt_used_sticky` goes to 1 in the cycle after the backup supply is first selected, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_in_tol | input | 1 | Asynchronous flag: supply within operating tolerance |
| vcc_above_sw | input | 1 | Asynchronous flag: supply above battery switchover level |
| vcc_above_seal | input | 1 | Asynchronous flag: supply above seal-release level |
| host_cs | input | 1 | Host chip select, active high |
| host_we | input | 1 | Host write enable, active high |
| host_oe | input | 1 | Host output enable, active high |
| arr_cs | output | 1 | Gated chip select to the array |
| arr_we | output | 1 | Gated write strobe to the array |
| dq_drive_en | output | 1 | Enable for the data output drivers |
| dq_force_hiz | output | 1 | Forces the data pins to high impedance while locked |
| pwr_sel_batt | output | 1 | 1 selects the backup source, 0 the main supply |
| seal_intact | output | 1 | 1 while the shipping seal is still in place |
| pf_state | output | 3 | State code: 0 sealed, 1 normal, 2 protected, 3 backup, 4 recovering |
| batt_used_sticky | output | 1 | Set once the backup source has been selected |

## Verification
The bench builds the block with SYNC_STAGES=2 and DEB_CYCLES=3. With a filter that short, a one-cycle glitch is rejected, and a full power-down, backup, recovery and reprotect sequence fits into a few hundred cycles. After each change of the flags the bench waits well past the sync-plus-filter latency, then compares the state code and every output against the values the requirements give. It also holds a write strobe active across a lockout to confirm that the aborted access does not resume.

// File: rtl/pfws_pkg.sv
package pfws_pkg;
  typedef enum logic [2:0] {
    ST_SEALED     = 3'd0,
    ST_NORMAL     = 3'd1,
    ST_PROTECTED  = 3'd2,
    ST_BACKUP     = 3'd3,
    ST_RECOVERING = 3'd4
  } pf_state_e;

  localparam int unsigned N_FLAGS = 3;
  localparam int unsigned FLG_TOL  = 0;
  localparam int unsigned FLG_SW   = 1;
  localparam int unsigned FLG_SEAL = 2;
endpackage

// File: rtl/pfws_flag_filter.sv
module pfws_flag_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_w;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  // synchronizer chain, one flop per stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end
  assign sync_w = sync_q[SYNC_STAGES-1];

  // stability counter: adopt the new level after DEB_CYCLES differing cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_w == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      filt_q <= sync_w;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
  assign filt_o = filt_q;

  // R1: filtered value only moves toward the synchronised value
  p_filter_follows_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(sync_w)));
  // R1: counter never exceeds its last value
  p_counter_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/pfws_fsm.sv
module pfws_fsm
  import pfws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tol_i,
  input  logic      sw_i,
  input  logic      seal_rel_i,
  output pf_state_e state_o,
  output logic      lock_o,
  output logic      batt_o,
  output logic      sealed_o,
  output logic      sticky_o
);
  pf_state_e state_q, state_d;
  logic      sealed_q, sticky_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEALED:     if (seal_rel_i) state_d = ST_RECOVERING;
      ST_NORMAL:     if (!tol_i)     state_d = ST_PROTECTED;
      ST_PROTECTED: begin
        if (!sw_i)      state_d = ST_BACKUP;
        else if (tol_i) state_d = ST_NORMAL;
      end
      ST_BACKUP:     if (sw_i)       state_d = ST_RECOVERING;
      ST_RECOVERING: begin
        if (!sw_i)      state_d = ST_BACKUP;
        else if (tol_i) state_d = ST_NORMAL;
      end
      default:       state_d = ST_SEALED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SEALED;
      sealed_q <= 1'b1;
      sticky_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SEALED && seal_rel_i) sealed_q <= 1'b0;
      if (state_q == ST_BACKUP)               sticky_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign lock_o   = (state_q != ST_NORMAL);
  assign batt_o   = (state_q == ST_BACKUP);
  assign sealed_o = sealed_q;
  assign sticky_o = sticky_q;

  // R3: once released, the seal never comes back
  p_seal_permanent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sealed_q |=> !sealed_q);
  // R4: the sealed state and the seal bit agree
  p_sealed_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEALED) |-> sealed_q);
  // R5: normal never survives a lost tolerance flag
  p_leave_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && !tol_i) |=> (state_q == ST_PROTECTED));
  // R6: low switchover flag in a locked, unsealed state leads to backup
  p_enter_backup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PROTECTED || state_q == ST_RECOVERING) && !sw_i) |=> (state_q == ST_BACKUP));
  // R7: backup is left only for recovering
  p_backup_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BACKUP && sw_i) |=> (state_q == ST_RECOVERING));
  // R10: sticky bit set after backup, never cleared
  p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BACKUP) |=> sticky_q);
  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q |=> sticky_q);
endmodule

// File: rtl/pfws_host_gate.sv
module pfws_host_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic host_cs,
  input  logic host_we,
  input  logic host_oe,
  output logic arr_cs,
  output logic arr_we,
  output logic drive_en
);
  logic aborted_q;
  logic block_w;

  // an access cut by the lock stays dead until chip select drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           aborted_q <= 1'b0;
    else if (!host_cs)    aborted_q <= 1'b0;
    else if (lock_i)      aborted_q <= 1'b1;
  end

  assign block_w  = lock_i | aborted_q;
  assign arr_cs   = host_cs & ~block_w;
  assign arr_we   = host_cs & host_we & ~block_w;
  assign drive_en = host_cs & host_oe & ~host_we & ~block_w;

  // R9: an aborted access is not revived while chip select stays high
  p_no_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && lock_i) |=> (!host_cs || !arr_cs));
  // R8: driver and write strobe never together
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_we && drive_en));
endmodule

// File: rtl/pfws_top.sv
module pfws_top
  import pfws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_in_tol,
  input  logic       vcc_above_sw,
  input  logic       vcc_above_seal,
  input  logic       host_cs,
  input  logic       host_we,
  input  logic       host_oe,
  output logic       arr_cs,
  output logic       arr_we,
  output logic       dq_drive_en,
  output logic       dq_force_hiz,
  output logic       pwr_sel_batt,
  output logic       seal_intact,
  output logic [2:0] pf_state,
  output logic       batt_used_sticky
);
  logic [N_FLAGS-1:0] raw_w, filt_w;
  pf_state_e          state_w;
  logic               lock_w;

  assign raw_w[FLG_TOL]  = vcc_in_tol;
  assign raw_w[FLG_SW]   = vcc_above_sw;
  assign raw_w[FLG_SEAL] = vcc_above_seal;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    pfws_flag_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_w[i]),
      .filt_o(filt_w[i])
    );
  end

  pfws_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tol_i     (filt_w[FLG_TOL]),
    .sw_i      (filt_w[FLG_SW]),
    .seal_rel_i(filt_w[FLG_SEAL]),
    .state_o   (state_w),
    .lock_o    (lock_w),
    .batt_o    (pwr_sel_batt),
    .sealed_o  (seal_intact),
    .sticky_o  (batt_used_sticky)
  );

  pfws_host_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_i  (lock_w),
    .host_cs (host_cs),
    .host_we (host_we),
    .host_oe (host_oe),
    .arr_cs  (arr_cs),
    .arr_we  (arr_we),
    .drive_en(dq_drive_en)
  );

  assign dq_force_hiz = lock_w;
  assign pf_state     = state_w;

  // R4: sealed part never selects the backup source
  p_sealed_no_batt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seal_intact |-> !pwr_sel_batt);
  // R5: array strobes only reach the array in the normal state
  p_strobe_only_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cs || arr_we || dq_drive_en) |-> (pf_state == 3'd1));
  // R6: battery selection and open interface are exclusive
  p_batt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_sel_batt |-> dq_force_hiz);
endmodule

// File: tb/sim_pfws_top.sv
module sim_pfws_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tol = 1'b0, sw = 1'b0, seal = 1'b0;
  logic cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic arr_cs, arr_we, drv, hiz, batt, sealed, sticky;
  logic [2:0] st;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pfws_top #(.SYNC_STAGES(2), .DEB_CYCLES(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .vcc_in_tol(tol), .vcc_above_sw(sw), .vcc_above_seal(seal),
    .host_cs(cs), .host_we(we), .host_oe(oe),
    .arr_cs(arr_cs), .arr_we(arr_we), .dq_drive_en(drv), .dq_force_hiz(hiz),
    .pwr_sel_batt(batt), .seal_intact(sealed), .pf_state(st),
    .batt_used_sticky(sticky)
  );

  typedef struct {
    string      req;
    logic [2:0] st;
    logic       batt, hiz, sealed, sticky, cs, we, drv;
  } exp_t;

  exp_t sb_q[$];

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic [8:0] act, expv;
      e = sb_q.pop_front();
      act  = {st, batt, hiz, sealed, sticky, arr_cs, arr_we};
      expv = {e.st, e.batt, e.hiz, e.sealed, e.sticky, e.cs, e.we};
      checks++;
      if (act !== expv || drv !== e.drv) begin
        failures++;
        $display("FAIL %s: actual st=%0d batt=%b hiz=%b seal=%b sticky=%b cs=%b we=%b drv=%b expected st=%0d batt=%b hiz=%b seal=%b sticky=%b cs=%b we=%b drv=%b",
                 e.req, st, batt, hiz, sealed, sticky, arr_cs, arr_we, drv,
                 e.st, e.batt, e.hiz, e.sealed, e.sticky, e.cs, e.we, e.drv);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver side: push an expectation, then let the monitor consume it
  task automatic expect_out(input string req, input logic [2:0] s, input logic b,
                            input logic h, input logic sl, input logic sk,
                            input logic c, input logic w, input logic d);
    exp_t e;
    e.req = req; e.st = s; e.batt = b; e.hiz = h; e.sealed = sl; e.sticky = sk;
    e.cs = c; e.we = w; e.drv = d;
    @(negedge clk);
    sb_q.push_back(e);
    wait_cyc(2);
  endtask

  localparam int SETTLE = 14;

  initial begin
    wait_cyc(3);
    cs = 1'b1; we = 1'b1;
    wait_cyc(1);
    // R2: reset state, strobes blocked
    expect_out("R2", 3'd0, 0, 1, 1, 0, 0, 0, 0);
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    expect_out("R2", 3'd0, 0, 1, 1, 0, 0, 0, 0);
    cs = 1'b0; we = 1'b0;

    // R4: supply up to switchover then back down while sealed
    sw = 1'b1; wait_cyc(SETTLE);
    expect_out("R4", 3'd0, 0, 1, 1, 0, 0, 0, 0);
    sw = 1'b0; wait_cyc(SETTLE);
    expect_out("R4", 3'd0, 0, 1, 1, 0, 0, 0, 0);

    // R1: one-cycle glitch on seal flag is rejected
    seal = 1'b1; wait_cyc(1); seal = 1'b0; wait_cyc(SETTLE);
    expect_out("R1", 3'd0, 0, 1, 1, 0, 0, 0, 0);

    // R3: seal released, goes to recovering
    sw = 1'b1; seal = 1'b1; wait_cyc(SETTLE);
    expect_out("R3", 3'd4, 0, 1, 0, 0, 0, 0, 0);
    // R7: in tolerance -> normal
    tol = 1'b1; wait_cyc(SETTLE);
    expect_out("R7", 3'd1, 0, 0, 0, 0, 0, 0, 0);

    // R8: write, read, read with write enable
    cs = 1'b1; we = 1'b1; wait_cyc(1);
    expect_out("R8", 3'd1, 0, 0, 0, 0, 1, 1, 0);
    we = 1'b0; oe = 1'b1; wait_cyc(1);
    expect_out("R8", 3'd1, 0, 0, 0, 0, 1, 0, 1);
    we = 1'b1; wait_cyc(1);
    expect_out("R8", 3'd1, 0, 0, 0, 0, 1, 1, 0);
    oe = 1'b0;

    // R5 / R9: write held through lockout
    tol = 1'b0; wait_cyc(SETTLE);
    expect_out("R5", 3'd2, 0, 1, 0, 0, 0, 0, 0);
    tol = 1'b1; wait_cyc(SETTLE);
    expect_out("R9", 3'd1, 0, 0, 0, 0, 0, 0, 0);
    cs = 1'b0; wait_cyc(2); cs = 1'b1; wait_cyc(1);
    expect_out("R9", 3'd1, 0, 0, 0, 0, 1, 1, 0);
    cs = 1'b0; we = 1'b0;

    // R6 / R10: full power loss, seal flag gone too
    tol = 1'b0; sw = 1'b0; seal = 1'b0; cs = 1'b1; we = 1'b1;
    wait_cyc(SETTLE);
    expect_out("R6", 3'd3, 1, 1, 0, 1, 0, 0, 0);
    cs = 1'b0; we = 1'b0;

    // R7: back above switchover, still locked; R3 seal stays released
    sw = 1'b1; wait_cyc(SETTLE);
    expect_out("R7", 3'd4, 0, 1, 0, 1, 0, 0, 0);
    expect_out("R3", 3'd4, 0, 1, 0, 1, 0, 0, 0);
    tol = 1'b1; wait_cyc(SETTLE);
    expect_out("R10", 3'd1, 0, 0, 0, 1, 0, 0, 0);

    // R5: brownout that stays above switchover keeps main supply
    tol = 1'b0; wait_cyc(SETTLE);
    expect_out("R5", 3'd2, 0, 1, 0, 1, 0, 0, 0);
    // R6: then drop below switchover from protected
    sw = 1'b0; wait_cyc(SETTLE);
    expect_out("R6", 3'd3, 1, 1, 0, 1, 0, 0, 0);
    // R1: one-cycle glitch on switchover flag does not leave backup
    sw = 1'b1; wait_cyc(1); sw = 1'b0; wait_cyc(SETTLE);
    expect_out("R1", 3'd3, 1, 1, 0, 1, 0, 0, 0);

    wait_cyc(4);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule